// File: doc/BRIEF.md
# Framed Word Serializer

This block turns a parallel data word into a framed serial bit stream. The word is captured on a chosen edge of a slow reference clock, which the block samples on its own fast clock. Every word travels in a 12-bit frame: a high start bit comes first, then the ten data bits least significant first, then a low stop bit. The framing guarantees at least one transition in every frame, so a receiver can recover the clock from the data. The block runs on a clock at twelve times the reference rate and emits one serial bit per cycle. Ten of every twelve bits carry payload.

After power-up the block waits in an initialization mode until a count of reference rising edges shows lock. It then sends a burst of synchronization frames and moves on to data transmission. A request input can send the block back into synchronization from data mode. The serial output comes with an enable. The enable stays low while the block is uninitialized, powered down or disabled, and the pad logic uses it to hold the line in high impedance.

Top module: `framed_serializer`

## Requirements
- R1: A frame is 12 consecutive `clk` cycles at bit positions 0 to 11. Position 0 carries 1 (start). Positions 1 to 10 carry data bits 0 to 9. Position 11 carries 0 (stop). The first frame boundary comes on the 12th rising `clk` edge after `pwr_on` rises, and a new frame starts on every 12th edge after that.
- R2: With `edge_sel` = 1, `din` is captured where `clk` sees a rising edge of `ref_clk`. With `edge_sel` = 0, it is captured at a falling edge. A data frame carries the word most recently captured before its frame boundary.
- R3: `ser_oe` is 1 only while `pwr_on` and `out_en` are both 1 and `mode` is not initialization. `ser_out` is 0 whenever `ser_oe` is 0.
- R4: `mode` reads 0 in initialization, 1 in synchronization and 2 in data. After power-up, `mode` stays 0 until LOCK_CYCLES rising `ref_clk` edges have been counted. It becomes 1 at the next frame boundary and never jumps straight from 0 to 2.
- R5: Synchronization sends at least SYNC_FRAMES frames whose data word is 10'h01F (bits 0 to 4 one, bits 5 to 9 zero). It switches to data at a frame boundary that ends the burst while `sync_req` is 0. While `sync_req` is 1 at those boundaries, it keeps sending sync frames.
- R6: In data mode, `sync_req` high at SYNC_HOLD consecutive rising `ref_clk` edges arms a return to synchronization. Dropping `sync_req` afterwards does not cancel it. The next frame boundary starts a fresh burst of SYNC_FRAMES. A shorter high run has no effect.
- R7: While `pwr_on` is 0 or `rst_n` is 0, `mode` returns to 0, the lock count is cleared and the bit position goes back to 0. After the next power-up the full lock wait repeats.
- R8: `mode` changes only at a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, twelve times the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Transmit reference clock, sampled on `clk` |
| edge_sel | input | 1 | 1: capture on reference rising edge, 0: on falling edge |
| din | input | 10 | Parallel data word |
| pwr_on | input | 1 | 0 powers the block down |
| out_en | input | 1 | 0 forces the output enable low |
| sync_req | input | 1 | Request for synchronization frames |
| ser_out | output | 1 | Serial bit stream |
| ser_oe | output | 1 | Output enable for the line driver |
| mode | output | 2 | 0 init, 1 sync, 2 data |

## Verification
A frame boundary can coincide with a change in the synchronization request. The last boundary of a sync burst decides between another sync frame and the first data frame, and it reads `sync_req` in that same cycle. The bench raises and drops the request next to those boundaries, both directed and at random. It also switches the edge select and the enable in the middle of frames. A cycle-level model in the bench predicts the mode of every frame and each serial bit, and each cycle is judged against that prediction.

// File: rtl/fser_pkg.sv
`timescale 1ns/1ps
package fser_pkg;
  parameter int unsigned FSER_WORD_W = 10;
  localparam int unsigned FSER_FRAME_W = FSER_WORD_W + 2;

  typedef enum logic [1:0] {
    M_INIT = 2'd0,
    M_SYNC = 2'd1,
    M_DATA = 2'd2
  } fser_mode_e;

  // Frame layout: bit 0 start (1), bits 1..W data LSB first, top bit stop (0).
  function automatic logic [FSER_FRAME_W-1:0] frame_of(input logic [FSER_WORD_W-1:0] w);
    return {1'b0, w, 1'b1};
  endfunction

  // Sync word: lower half of the bits set, upper half clear.
  function automatic logic [FSER_WORD_W-1:0] sync_word();
    logic [FSER_WORD_W-1:0] w;
    for (int i = 0; i < FSER_WORD_W; i++) w[i] = (i < FSER_WORD_W / 2);
    return w;
  endfunction
endpackage

// File: rtl/fser_edge_latch.sv
`timescale 1ns/1ps
module fser_edge_latch #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ref_clk,
  input  logic         edge_sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] held_word,
  output logic         ref_rise
);
  logic ref_q;
  logic ref_fall;
  logic take;

  assign ref_rise = ref_clk & ~ref_q;
  assign ref_fall = ~ref_clk & ref_q;
  assign take     = edge_sel ? ref_rise : ref_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q     <= 1'b0;
      held_word <= '0;
    end else begin
      ref_q <= ref_clk;
      if (take) held_word <= din;
    end
  end
endmodule

// File: rtl/fser_mode_ctrl.sv
`timescale 1ns/1ps
module fser_mode_ctrl
  import fser_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 2048,
  parameter int unsigned SYNC_FRAMES = 1024,
  parameter int unsigned SYNC_HOLD   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on,
  input  logic       ref_rise,
  input  logic       sync_req,
  input  logic       wrap,
  output fser_mode_e mode_q,
  output fser_mode_e mode_nxt
);
  localparam int unsigned LOCK_W = $clog2(LOCK_CYCLES + 1);
  localparam int unsigned LEFT_W = $clog2(SYNC_FRAMES + 1);
  localparam int unsigned HOLD_W = $clog2(SYNC_HOLD + 1);

  logic [LOCK_W-1:0] lock_cnt;
  logic [LEFT_W-1:0] left_cnt;
  logic [HOLD_W-1:0] hold_cnt;
  logic              armed;
  logic              locked;
  logic              burst_done;
  logic              enter_sync;

  assign locked     = (lock_cnt == LOCK_W'(LOCK_CYCLES));
  assign burst_done = (left_cnt <= LEFT_W'(1));

  always_comb begin
    mode_nxt = mode_q;
    if (wrap) begin
      unique case (mode_q)
        M_INIT:  if (locked) mode_nxt = M_SYNC;
        M_SYNC:  if (burst_done && !sync_req) mode_nxt = M_DATA;
        M_DATA:  if (armed) mode_nxt = M_SYNC;
        default: mode_nxt = M_INIT;
      endcase
    end
  end

  assign enter_sync = wrap && (mode_q != M_SYNC) && (mode_nxt == M_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_INIT;
      lock_cnt <= '0;
      left_cnt <= '0;
      hold_cnt <= '0;
      armed    <= 1'b0;
    end else if (!pwr_on) begin
      mode_q   <= M_INIT;
      lock_cnt <= '0;
      left_cnt <= '0;
      hold_cnt <= '0;
      armed    <= 1'b0;
    end else begin
      mode_q <= mode_nxt;
      if (ref_rise && !locked) lock_cnt <= lock_cnt + 1'b1;
      if (enter_sync) left_cnt <= LEFT_W'(SYNC_FRAMES);
      else if (wrap && mode_q == M_SYNC && !burst_done) left_cnt <= left_cnt - 1'b1;
      if (mode_q != M_DATA || enter_sync) begin
        hold_cnt <= '0;
        armed    <= 1'b0;
      end else if (ref_rise) begin
        if (sync_req) begin
          if (hold_cnt == HOLD_W'(SYNC_HOLD - 1)) armed <= 1'b1;
          if (!armed) hold_cnt <= hold_cnt + 1'b1;
        end else begin
          hold_cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fser_shifter.sv
`timescale 1ns/1ps
module fser_shifter
  import fser_pkg::*;
#(
  parameter int unsigned W = FSER_WORD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pwr_on,
  input  logic [W-1:0]             held_word,
  input  logic                     use_sync,
  output logic [$clog2(W+2)-1:0]   bit_pos,
  output logic                     wrap,
  output logic                     bit_val
);
  localparam int unsigned FW    = W + 2;
  localparam int unsigned POS_W = $clog2(FW);

  logic [FW-1:0] frame_q;

  assign wrap    = (bit_pos == POS_W'(FW - 1));
  assign bit_val = frame_q[bit_pos];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos <= '0;
      frame_q <= '0;
    end else if (!pwr_on) begin
      bit_pos <= '0;
      frame_q <= '0;
    end else begin
      bit_pos <= wrap ? '0 : bit_pos + 1'b1;
      if (wrap) frame_q <= use_sync ? frame_of(sync_word()) : frame_of(held_word);
    end
  end
endmodule

// File: rtl/framed_serializer.sv
`timescale 1ns/1ps
module framed_serializer
  import fser_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 2048,
  parameter int unsigned SYNC_FRAMES = 1024,
  parameter int unsigned SYNC_HOLD   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ref_clk,
  input  logic                   edge_sel,
  input  logic [FSER_WORD_W-1:0] din,
  input  logic                   pwr_on,
  input  logic                   out_en,
  input  logic                   sync_req,
  output logic                   ser_out,
  output logic                   ser_oe,
  output logic [1:0]             mode
);
  localparam int unsigned POS_W = $clog2(FSER_FRAME_W);

  logic [FSER_WORD_W-1:0] held_word;
  logic                   ref_rise;
  logic [POS_W-1:0]       bit_pos;
  logic                   wrap;
  logic                   bit_val;
  fser_mode_e             mode_q;
  fser_mode_e             mode_nxt;

  fser_edge_latch #(.W(FSER_WORD_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .edge_sel(edge_sel),
    .din(din), .held_word(held_word), .ref_rise(ref_rise)
  );

  fser_mode_ctrl #(
    .LOCK_CYCLES(LOCK_CYCLES), .SYNC_FRAMES(SYNC_FRAMES), .SYNC_HOLD(SYNC_HOLD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .ref_rise(ref_rise),
    .sync_req(sync_req), .wrap(wrap), .mode_q(mode_q), .mode_nxt(mode_nxt)
  );

  fser_shifter #(.W(FSER_WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .held_word(held_word),
    .use_sync(mode_nxt == M_SYNC), .bit_pos(bit_pos), .wrap(wrap), .bit_val(bit_val)
  );

  assign ser_oe  = pwr_on & out_en & (mode_q != M_INIT);
  assign ser_out = ser_oe & bit_val;
  assign mode    = mode_q;
endmodule

// File: rtl/fser_chk.sv
`timescale 1ns/1ps
module fser_chk #(
  parameter int unsigned POS_W = 4,
  parameter int unsigned LAST  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_on,
  input logic [1:0]       mode,
  input logic [POS_W-1:0] bit_pos,
  input logic             wrap,
  input logic             ser_out,
  input logic             ser_oe
);
  a_r1_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && bit_pos == '0) |-> ser_out);

  a_r1_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && bit_pos == POS_W'(LAST)) |-> !ser_out);

  a_r7_pwrdn_init: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (mode == 2'd0 && bit_pos == '0));

  a_r8_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && !wrap) |=> $stable(mode));

  a_r4_init_not_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> (mode != 2'd2));
endmodule

bind framed_serializer fser_chk #(.POS_W(POS_W), .LAST(FSER_FRAME_W - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .mode(mode), .bit_pos(bit_pos),
  .wrap(wrap), .ser_out(ser_out), .ser_oe(ser_oe)
);

// File: tb/sim_framed_serializer.sv
`timescale 1ns/1ps
module sim_framed_serializer;
  localparam int L = 40;
  localparam int S = 4;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       edge_sel = 1'b1;
  logic [9:0] din = '0;
  logic       pwr_on = 1'b0;
  logic       out_en = 1'b1;
  logic       sync_req = 1'b0;
  logic       ser_out, ser_oe;
  logic [1:0] mode;

  always #2.5 clk = ~clk;

  framed_serializer #(.LOCK_CYCLES(L), .SYNC_FRAMES(S), .SYNC_HOLD(H)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .edge_sel(edge_sel), .din(din),
    .pwr_on(pwr_on), .out_en(out_en), .sync_req(sync_req),
    .ser_out(ser_out), .ser_oe(ser_oe), .mode(mode)
  );

  int nchk = 0, nerr = 0;
  int n = 0;                 // rising edges since power-up
  int bm = 0, blk = 0, bleft = 0, bhold = 0;
  bit barmed = 0;
  int dpat = 0;              // 0 random, 1 all zeros, 2 all ones
  logic [9:0]  cap = '0;
  logic [11:0] efr = '0;
  bit done = 0;

  // Expected frame: start bit, data LSB first, stop bit.
  function automatic logic [11:0] mkframe(input logic [9:0] w);
    logic [11:0] f;
    f[0] = 1'b1;
    for (int i = 0; i < 10; i++) f[i+1] = w[i];
    f[11] = 1'b0;
    return f;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s at n=%0d: actual %0d expected %0d", tag, n, act, exp);
    end
  endtask

  task automatic model_step();
    int ph = n % 12;
    if (ph == 1) begin
      if (edge_sel) cap = din;
      if (bm == 0 && blk < L) blk++;
      if (bm == 2) begin
        if (sync_req) begin bhold++; if (bhold >= H) barmed = 1; end
        else bhold = 0;
      end
    end
    if (ph == 7 && !edge_sel) cap = din;
    if (ph == 0) begin
      case (bm)
        0: if (blk == L) begin bm = 1; bleft = S; end
        1: if (bleft <= 1 && !sync_req) bm = 2; else if (bleft > 1) bleft--;
        default: if (barmed) begin bm = 1; bleft = S; barmed = 0; bhold = 0; end
      endcase
      efr = (bm == 1) ? mkframe(10'h01F) : mkframe(cap);
    end
  endtask

  task automatic do_checks();
    if (!rst_n || !pwr_on) begin
      chk("R7 mode", int'(mode), 0);
      chk("R7 oe", int'(ser_oe), 0);
      chk("R7 out", int'(ser_out), 0);
    end else begin
      int p = n % 12;
      bit oe_e = out_en && (bm != 0);
      chk("R3 oe", int'(ser_oe), int'(oe_e));
      chk("R8 mode", int'(mode), bm);
      if (n == 12*L - 1) chk("R4 still init", int'(mode), 0);
      if (n == 12*L)     chk("R4 sync entry", int'(mode), 1);
      if (!oe_e)             chk("R3 out low", int'(ser_out), 0);
      else if (p == 0 || p == 11) chk("R1 framing", int'(ser_out), int'(efr[p]));
      else if (bm == 1)      chk("R5 sync bit", int'(ser_out), int'(efr[p]));
      else                   chk("R2 data bit", int'(ser_out), int'(efr[p]));
    end
  endtask

  task automatic drive();
    int ph = n % 12;
    ref_clk = (ph < 6);
    if (ph == 3 || ph == 9)
      din = (dpat == 1) ? 10'h000 : (dpat == 2) ? 10'h3FF : 10'($urandom);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (pwr_on && rst_n) begin n++; model_step(); end
    do_checks();
    if (pwr_on && rst_n) drive();
  endtask

  task automatic power_up();
    n = 0; bm = 0; blk = 0; bleft = 0; bhold = 0; barmed = 0;
    efr = '0;
    pwr_on = 1'b1;
    ref_clk = 1'b1;
  endtask

  task automatic power_down();
    pwr_on = 1'b0;
    ref_clk = 1'b0;
  endtask

  task automatic to_boundary();
    tick();
    while (n % 12 != 0) tick();
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    run(3);                       // reset state (R7)
    rst_n = 1'b1;
    run(3);
    // First power-up, rising-edge capture; lock wait and sync burst (R4, R5).
    power_up();
    run(12*L + 12*S + 400);
    // Falling-edge capture (R2).
    edge_sel = 1'b0;
    run(400);
    // Constant words still carry start/stop transitions (R1).
    dpat = 1; run(60);
    dpat = 2; run(60);
    dpat = 0;
    // Enable dropped mid-frame (R3).
    run(5); out_en = 1'b0; run(50); out_en = 1'b1; run(30);
    // Short request: no arming (R6).
    to_boundary();
    sync_req = 1'b1; run(12*3); sync_req = 1'b0;
    to_boundary(); to_boundary();
    chk("R6 short request ignored", int'(mode), 2);
    // Long request released before the boundary: arming persists (R6).
    sync_req = 1'b1; run(12*H + 2); sync_req = 1'b0;
    to_boundary();
    chk("R6 armed return to sync", int'(mode), 1);
    run(12*S + 24);
    chk("R5 burst ends", int'(mode), 2);
    // Held request extends the burst (R5).
    sync_req = 1'b1; run(12*(H + S + 3));
    chk("R5 held request keeps sync", int'(mode), 1);
    sync_req = 1'b0; run(12*(S + 1));
    // Power-down mid-frame and full relock (R7).
    run(5); power_down(); run(30);
    edge_sel = 1'b1;
    power_up();
    run(12*L + 12*S + 100);
    // Constrained random mix.
    for (int i = 0; i < 6000; i++) begin
      tick();
      if ($urandom_range(0, 39) == 0) sync_req = ~sync_req;
      if ($urandom_range(0, 149) == 0) out_en = ~out_en;
      if ($urandom_range(0, 199) == 0) edge_sel = ~edge_sel;
      if ($urandom_range(0, 2999) == 0) begin
        power_down(); run(20); power_up();
      end
    end
    sync_req = 1'b0; out_en = 1'b1;
    run(100);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule